// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller keeps track of which operating mode a microcontroller core is in and moves it between modes in response to stop and sleep instruction strobes, a few configuration flags and wake events. There are five operating modes: full-speed active, slow subactive (the core runs from the sub-oscillator), watch (only the sub-oscillator and the clock timer run), standby (main oscillator running, core clock gated) and stop (both oscillators off). A sixth state, the settling wait, holds the core clock off after the main oscillator restarts. It lasts a programmable number of cycles and then hands over to active mode.

For each mode the block drives enables for the main and sub oscillators, a core clock gate, a ready flag for the full-speed clock and an A/D enable. It also holds the subactive instruction-speed select bit. That bit accepts writes only in active mode. A write in any other mode is dropped and raises a sticky error flag. Every output is registered. All outputs, including the mode code, change on the clock edge that samples the causing input.

Top module: `lpm_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the mode is active (code 0), all five enables (`main_osc_en`, `sub_osc_en`, `cpu_clk_en`, `core_ready`, `adc_en`) are 1, and `spd_sel` and `spd_err` are 0.
- R2: The transitions out of active mode are as follows. `stop_req` with `tmr_mode`=1 goes to watch (code 2). `stop_req` with `tmr_mode`=0 goes to stop (code 4). `sleep_req` alone goes to standby (code 3). When both strobes are present, `stop_req` wins.
- R3: In watch mode, `main_osc_en`=0, `sub_osc_en`=1, and `cpu_clk_en`, `core_ready` and `adc_en` are 0. The mode stays in watch until `wake_tmr`, `wake_ext` or `wake_rst` is seen.
- R4: A `wake_tmr` or `wake_ext` in watch goes to subactive (code 1) when `low_spd`=1. When `low_spd`=0 it goes to the settling wait (code 5) and then to active.
- R5: In subactive mode, `main_osc_en`=0, `sub_osc_en`=1, `cpu_clk_en`=1, `core_ready`=0 and `adc_en`=0. A `stop_req` or `sleep_req` goes to the settling wait when `low_spd`=0 and `direct_xfer`=1. In every other flag combination it goes to watch.
- R6: The settling wait lasts max(`stab_len`,1) cycles, then the mode becomes active. Throughout the wait, `main_osc_en`=1, `sub_osc_en`=1, and `cpu_clk_en`, `core_ready` and `adc_en` are 0.
- R7: `wake_rst` has priority over every other input. From subactive, watch or stop it leads to the settling wait. From active or standby it leads straight to active.
- R8: In stop mode all five enables are 0. Stop mode is left only on `wake_ext` or `wake_rst`, and in both cases it goes to the settling wait. `wake_tmr` is ignored in stop mode.
- R9: In standby mode, `main_osc_en`=1, `sub_osc_en`=1, and `cpu_clk_en`, `core_ready` and `adc_en` are 0. Any of `wake_tmr`, `wake_ext` or `wake_rst` returns to active on the next edge.
- R10: `spd_wr` loads `spd_wdata` into `spd_sel` only in active mode. A write in any other mode leaves `spd_sel` unchanged and sets `spd_err`, which then stays 1 until `rst`.
- R11: Every output changes on the first rising edge at which the causing input is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop instruction strobe |
| sleep_req | input | 1 | Sleep instruction strobe |
| tmr_mode | input | 1 | Timer-mode select: stop in active enters watch when 1 |
| low_spd | input | 1 | Low-speed flag: wake into subactive when 1 |
| direct_xfer | input | 1 | Direct-transfer flag for subactive to active |
| wake_tmr | input | 1 | Timer interrupt wake request |
| wake_ext | input | 1 | External interrupt wake request |
| wake_rst | input | 1 | Reset-pin wake request |
| spd_wr | input | 1 | Speed-select write strobe |
| spd_wdata | input | 1 | Speed-select write data |
| stab_len | input | CNT_W | Settling wait length in cycles |
| mode_o | output | 3 | Current mode code |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| core_ready | output | 1 | Core running on stable main clock |
| adc_en | output | 1 | A/D converter enable |
| spd_sel | output | 1 | Subactive instruction-speed select |
| spd_err | output | 1 | Sticky illegal speed-write flag |

## Verification
Every result of this block is due exactly one rising edge after the input cycle that causes it. The mode code, the five enables, the speed bit and the error flag all come from registers loaded from the next-state decode. The driver applies each stimulus just after a falling edge and queues the expected outputs for that cycle. The monitor takes one entry off the queue shortly after each following rising edge, so no sample falls on a transition. The settling wait is covered for one-cycle and multi-cycle lengths by counting one queued entry per wait cycle before the entry that expects active mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_ACTIVE  = 3'd0,
    M_SUB     = 3'd1,
    M_WATCH   = 3'd2,
    M_STANDBY = 3'd3,
    M_STOP    = 3'd4,
    M_SETTLE  = 3'd5
  } mode_t;

  typedef struct packed {
    logic main_osc;
    logic sub_osc;
    logic cpu_clk;
    logic ready;
    logic adc;
  } ctl_t;

  function automatic ctl_t ctl_of(mode_t m);
    ctl_t c;
    c = '0;
    case (m)
      M_ACTIVE:  c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
      M_SUB:     c = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      M_WATCH:   c = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
      M_STANDBY: c = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
      M_SETTLE:  c = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
      default:   c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lpm_next.sv
module lpm_next
  import lpm_pkg::*;
(
  input  mode_t cur,
  input  logic  stop_req,
  input  logic  sleep_req,
  input  logic  tmr_mode,
  input  logic  low_spd,
  input  logic  direct_xfer,
  input  logic  wake_tmr,
  input  logic  wake_ext,
  input  logic  wake_rst,
  input  logic  settle_done,
  output mode_t nxt
);

  logic any_irq;
  logic sleep_any;
  assign any_irq   = wake_tmr | wake_ext;
  assign sleep_any = stop_req | sleep_req;

  always_comb begin
    nxt = cur;
    case (cur)
      M_ACTIVE: begin
        if (wake_rst)       nxt = M_ACTIVE;
        else if (stop_req)  nxt = tmr_mode ? M_WATCH : M_STOP;
        else if (sleep_req) nxt = M_STANDBY;
      end
      M_SUB: begin
        if (wake_rst)        nxt = M_SETTLE;
        else if (sleep_any)  nxt = (!low_spd && direct_xfer) ? M_SETTLE : M_WATCH;
      end
      M_WATCH: begin
        if (wake_rst)      nxt = M_SETTLE;
        else if (any_irq)  nxt = low_spd ? M_SUB : M_SETTLE;
      end
      M_STANDBY: begin
        if (wake_rst || any_irq) nxt = M_ACTIVE;
      end
      M_STOP: begin
        if (wake_rst || wake_ext) nxt = M_SETTLE;
      end
      M_SETTLE: begin
        if (settle_done) nxt = M_ACTIVE;
      end
      default: nxt = M_ACTIVE;
    endcase
  end

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EW-1:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt} + EW'(1);
  assign done    = run && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!done)  cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/lpm_speed_reg.sv
module lpm_speed_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  input  logic allowed,
  output logic sel,
  output logic err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= 1'b0;
      err <= 1'b0;
    end else if (wr) begin
      if (allowed) sel <= wdata;
      else         err <= 1'b1;
    end
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic             sleep_req,
  input  logic             tmr_mode,
  input  logic             low_spd,
  input  logic             direct_xfer,
  input  logic             wake_tmr,
  input  logic             wake_ext,
  input  logic             wake_rst,
  input  logic             spd_wr,
  input  logic             spd_wdata,
  input  logic [CNT_W-1:0] stab_len,
  output logic [2:0]       mode_o,
  output logic             main_osc_en,
  output logic             sub_osc_en,
  output logic             cpu_clk_en,
  output logic             core_ready,
  output logic             adc_en,
  output logic             spd_sel,
  output logic             spd_err
);

  mode_t mode_q;
  mode_t mode_d;
  ctl_t  ctl_q;
  logic  settle_done;

  lpm_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (mode_q == M_SETTLE),
    .limit (stab_len),
    .done  (settle_done)
  );

  lpm_next u_next (
    .cur         (mode_q),
    .stop_req    (stop_req),
    .sleep_req   (sleep_req),
    .tmr_mode    (tmr_mode),
    .low_spd     (low_spd),
    .direct_xfer (direct_xfer),
    .wake_tmr    (wake_tmr),
    .wake_ext    (wake_ext),
    .wake_rst    (wake_rst),
    .settle_done (settle_done),
    .nxt         (mode_d)
  );

  lpm_speed_reg u_speed (
    .clk     (clk),
    .rst     (rst),
    .wr      (spd_wr),
    .wdata   (spd_wdata),
    .allowed (mode_q == M_ACTIVE),
    .sel     (spd_sel),
    .err     (spd_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_ACTIVE;
      ctl_q  <= ctl_of(M_ACTIVE);
    end else begin
      mode_q <= mode_d;
      ctl_q  <= ctl_of(mode_d);
    end
  end

  assign mode_o      = mode_q;
  assign main_osc_en = ctl_q.main_osc;
  assign sub_osc_en  = ctl_q.sub_osc;
  assign cpu_clk_en  = ctl_q.cpu_clk;
  assign core_ready  = ctl_q.ready;
  assign adc_en      = ctl_q.adc;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic       sleep_req,
  input logic       wake_tmr,
  input logic       wake_ext,
  input logic       wake_rst,
  input logic       spd_wr,
  input logic [2:0] mode_o,
  input logic       main_osc_en,
  input logic       sub_osc_en,
  input logic       cpu_clk_en,
  input logic       adc_en,
  input logic       spd_sel,
  input logic       spd_err
);

  p_watch_clocks_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_WATCH) |-> (!main_osc_en && sub_osc_en && !cpu_clk_en));

  p_watch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_WATCH && !wake_tmr && !wake_ext && !wake_rst) |=> (mode_o == M_WATCH));

  p_sub_clocks_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_SUB) |-> (!main_osc_en && cpu_clk_en && !adc_en));

  p_settle_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_SETTLE) |-> (main_osc_en && !cpu_clk_en));

  p_rst_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (wake_rst && (mode_o == M_WATCH || mode_o == M_STOP || mode_o == M_SUB))
      |=> (mode_o == M_SETTLE));

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_STOP && !wake_ext && !wake_rst) |=> (mode_o == M_STOP && !sub_osc_en));

  p_standby_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_STANDBY && (wake_tmr || wake_ext || wake_rst)) |=> (mode_o == M_ACTIVE));

  p_spd_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (spd_wr && mode_o != M_ACTIVE) |=> ($stable(spd_sel) && spd_err));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    spd_err |=> spd_err);

  p_active_sleep_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_ACTIVE && !wake_rst && sleep_req && !stop_req) |=> (mode_o == M_STANDBY));

endmodule

bind lpm_seq lpm_seq_chk u_chk (.*);

// File: tb/lpm_seq_tb.sv
`timescale 1ns/1ps
module lpm_seq_tb;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, sleep_req = 0, tmr_mode = 0, low_spd = 0, direct_xfer = 0;
  logic wake_tmr = 0, wake_ext = 0, wake_rst = 0, spd_wr = 0, spd_wdata = 0;
  logic [CNT_W-1:0] stab_len = '0;
  logic [2:0] mode_o;
  logic main_osc_en, sub_osc_en, cpu_clk_en, core_ready, adc_en, spd_sel, spd_err;

  always #2 clk = ~clk;

  lpm_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .sleep_req(sleep_req),
    .tmr_mode(tmr_mode), .low_spd(low_spd), .direct_xfer(direct_xfer),
    .wake_tmr(wake_tmr), .wake_ext(wake_ext), .wake_rst(wake_rst),
    .spd_wr(spd_wr), .spd_wdata(spd_wdata), .stab_len(stab_len),
    .mode_o(mode_o), .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
    .cpu_clk_en(cpu_clk_en), .core_ready(core_ready), .adc_en(adc_en),
    .spd_sel(spd_sel), .spd_err(spd_err)
  );

  localparam logic [2:0] ACT = 0, SUB = 1, WAT = 2, STB = 3, STP = 4, SET = 5;

  typedef struct {
    logic [2:0] m;
    logic [4:0] c;
    logic       s;
    logic       e;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic exp_sel = 0, exp_err = 0;
  bit   done = 0;

  // {main, sub, cpu, ready, adc} per mode, from the requirements
  function automatic logic [4:0] exp_ctl(logic [2:0] m);
    case (m)
      ACT:     return 5'b11111;
      SUB:     return 5'b01100;
      WAT:     return 5'b01000;
      STB:     return 5'b11000;
      SET:     return 5'b11000;
      default: return 5'b00000;
    endcase
  endfunction

  // pulses = {stop, sleep, wtmr, wext, wrst, spd_wr, spd_wdata}
  task automatic drive(input logic [6:0] p, input logic [2:0] em, input string tag);
    item_t it;
    @(negedge clk);
    {stop_req, sleep_req, wake_tmr, wake_ext, wake_rst, spd_wr, spd_wdata} = p;
    it.m = em; it.c = exp_ctl(em); it.s = exp_sel; it.e = exp_err; it.tag = tag;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!rst && q.size() > 0) begin
      item_t it;
      logic [4:0] act_c;
      it = q.pop_front();
      act_c = {main_osc_en, sub_osc_en, cpu_clk_en, core_ready, adc_en};
      checks++;
      if (mode_o !== it.m || act_c !== it.c || spd_sel !== it.s || spd_err !== it.e) begin
        errors++;
        $display("FAIL %s: mode/ctl/sel/err actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
                 it.tag, mode_o, act_c, spd_sel, spd_err, it.m, it.c, it.s, it.e);
      end
    end
  end

  localparam logic [6:0] IDLE = 7'b0000000, STOP = 7'b1000000, SLEEP = 7'b0100000,
                         WTMR = 7'b0010000, WEXT = 7'b0001000, WRST = 7'b0000100;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (mode_o !== ACT || {main_osc_en, sub_osc_en, cpu_clk_en, core_ready, adc_en} !== 5'b11111
        || spd_sel !== 1'b0 || spd_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset mode %0d sel %b err %b expected 0/0/0", mode_o, spd_sel, spd_err);
    end
    rst = 1'b0;
    drive(IDLE, ACT, "R1 after reset");
    exp_sel = 1;
    drive(7'b0000011, ACT, "R10 write in active");
    tmr_mode = 1;
    drive(STOP, WAT, "R2 stop tmr_mode=1");
    drive(IDLE, WAT, "R3 watch holds");
    low_spd = 1;
    drive(WTMR, SUB, "R4 wake to subactive");
    exp_err = 1;
    drive(7'b0000010, SUB, "R10 write outside active ignored");
    low_spd = 0; direct_xfer = 1; stab_len = 8'd3;
    drive(SLEEP, SET, "R5 direct transfer");
    drive(IDLE, SET, "R6 wait 2");
    drive(IDLE, SET, "R6 wait 3");
    drive(IDLE, ACT, "R6 wait done R11");
    tmr_mode = 0; stab_len = 8'd0;
    drive(STOP, STP, "R2 stop tmr_mode=0");
    drive(WTMR, STP, "R8 timer ignored");
    drive(WEXT, SET, "R8 ext wake");
    drive(IDLE, ACT, "R6 zero length");
    drive(STOP | SLEEP, STP, "R2 stop wins");
    drive(WRST, SET, "R7 from stop");
    drive(IDLE, ACT, "R7 settle");
    drive(SLEEP, STB, "R2 sleep");
    drive(IDLE, STB, "R9 standby holds");
    drive(WTMR, ACT, "R9 wake");
    tmr_mode = 1;
    drive(STOP, WAT, "R2 to watch");
    drive(WEXT, SET, "R4 low_spd=0");
    drive(IDLE, ACT, "R4 to active");
    drive(STOP, WAT, "R2 watch again");
    low_spd = 1;
    drive(WTMR, SUB, "R4 sub");
    direct_xfer = 0;
    drive(STOP, WAT, "R5 direct=0");
    drive(WRST | WTMR, SET, "R7 priority");
    drive(IDLE, ACT, "R7 done");
    drive(STOP | WRST, ACT, "R7 in active");
    drive(STOP, WAT, "R2 watch");
    drive(WTMR, SUB, "R4 sub");
    direct_xfer = 1;
    drive(SLEEP, WAT, "R5 low_spd=1 direct=1");
    drive(WRST, SET, "R7 from watch");
    drive(IDLE, ACT, "R10 err sticky");
    @(negedge clk);
    {stop_req, sleep_req, wake_tmr, wake_ext, wake_rst, spd_wr, spd_wdata} = IDLE;
    while (q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule